// File: doc/BRIEF.md
# SCSI Target Bus Phase Sequencer

This block owns the three phase lines (message, control/data and input/output) of a SCSI target and the enable of its bus drivers. The target controller asks for a new bus phase through a valid/ready request port. The sequencer waits until the initiator's acknowledge line is quiet, changes the lines, and then holds off a settle time before it reports completion with a one-cycle done pulse. The controller must not start the handshake of the new phase before that pulse.

The settle time grows when the transfer direction (the I/O line) flips and grows again in legacy compatibility mode. In legacy mode, entering either data phase also inserts a long pause before the lines move at all. Every time is given in nanoseconds and converted to clock cycles from a clock-period parameter. A request for the phase already in effect finishes at once. A release request lets go of every line at once. A bus reset flag aborts any pending work and returns the block to bus-free.

Back-pressure: `req_ready` is high only while the sequencer is idle and the bus reset flag is low. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester keeps `req_phase` and `legacy_mode` stable while `req_valid` waits for ready. Only one request is in flight at a time.

Top module: `scsi_phase_seq`

## Requirements
- R1: After `rst_n` is released the block is bus-free: `drv_en` and all three phase lines are 0, `done` is 0 and `req_ready` is 1.
- R2: `req_ready` is 1 only while no request is in progress and `bus_rst` is 0. From the edge that takes a request until its `done` pulse, `req_ready` stays 0, except for the zero-delay completions in R3.
- R3: A request for the phase already in effect (an identical driven code, or a release code while bus-free) raises `done` in the cycle right after acceptance. It changes no line, even while ACK is high.
- R4: Any other request changes no line while `ack_in` is 1. Once `ack_in` is sampled 0 on an edge, the lines change on that same edge, or after the R8 pause.
- R5: Phase code `req_phase[3:0]`: bit 3 set means release (bus-free), and bits 2..0 are then ignored. Otherwise bit 2 drives `phase_msg`, bit 1 drives `phase_cd`, bit 0 drives `phase_io`, and `drv_en` is 1. DATA OUT is code 0 and DATA IN is code 1.
- R6: A release request, after the ACK wait, sets `drv_en` and all phase lines to 0 and raises `done` on that same edge, with no settle time.
- R7: After a driven phase change, `done` rises exactly S clock edges after the edge that changed the lines. S = cyc(SETTLE_NS), plus cyc(IOFLIP_NS) if `phase_io` differs from its previous value (a bus-free previous state counts as I/O = 0), plus cyc(LEGACY_NS) if `legacy_mode` was 1 at acceptance.
- R8: With `legacy_mode` 1 at acceptance and a target code of 0 or 1, the lines change cyc(PRE_NS) edges after the edge that first sampled `ack_in` at 0. The R7 settle then follows.
- R9: While `bus_rst` is 1, `req_ready` is 0. On the next edge the block is bus-free, with all lines and `drv_en` at 0. A request in progress is dropped and never gets a `done` pulse.
- R10: cyc(t) = ceil(t * 1000 / CLK_PS) clock cycles, and at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Phase request valid |
| req_ready | output | 1 | Sequencer can take a request |
| req_phase | input | 4 | Requested phase code (R5) |
| legacy_mode | input | 1 | Legacy compatibility timing, sampled at acceptance |
| ack_in | input | 1 | Initiator acknowledge line, 1 = asserted |
| bus_rst | input | 1 | Bus reset flag, 1 = reset active |
| phase_msg | output | 1 | Message phase line |
| phase_cd | output | 1 | Control/data phase line |
| phase_io | output | 1 | Input/output phase line |
| drv_en | output | 1 | Output enable for all bus drivers |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions check the following: no line moves on an edge where ACK was asserted, an accepted request leaves the block busy or done, the lines are 0 whenever the drivers are released, and a reset flag forces bus-free with no done pulse. A cycle counter in the checker also shows that no done pulse after a driven change comes before the base settle time. The exact settle lengths for every pair of phases, the extra time when the I/O direction flips, the legacy pre-data pause and its ceiling rounding can only be shown by the bench. It sweeps all 81 from/to phase pairs in both modes and computes the expected cycle counts arithmetically.

// File: rtl/scsi_seq_pkg.sv
package scsi_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACKWAIT,
    ST_PRE,
    ST_SETTLE
  } seq_state_t;

  localparam int PHASE_W = 4;
  localparam int REL_BIT = 3;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int clk_ps);
    longint num;
    int     c;
    num = longint'(ns) * 64'd1000 + longint'(clk_ps) - 64'd1;
    c   = int'(num / longint'(clk_ps));
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/scsi_seq_delay.sv
module scsi_seq_delay
  import scsi_seq_pkg::*;
#(
  parameter int CLK_PS    = 5000,
  parameter int SETTLE_NS = 400,
  parameter int IOFLIP_NS = 400,
  parameter int LEGACY_NS = 100000,
  parameter int PRE_NS    = 400000,
  parameter int CNT_W     = 17
) (
  input  logic             legacy,
  input  logic             io_flip,
  output logic [CNT_W-1:0] settle_m1,
  output logic [CNT_W-1:0] pre_m1
);

  localparam int SET_C = ns_to_cyc(SETTLE_NS, CLK_PS);
  localparam int FLP_C = ns_to_cyc(IOFLIP_NS, CLK_PS);
  localparam int LEG_C = ns_to_cyc(LEGACY_NS, CLK_PS);
  localparam int PRE_C = ns_to_cyc(PRE_NS, CLK_PS);

  int total;

  always_comb begin
    total = SET_C;
    if (io_flip) total = total + FLP_C;
    if (legacy)  total = total + LEG_C;
    settle_m1 = CNT_W'(total - 1);
    pre_m1    = CNT_W'(PRE_C - 1);
  end

endmodule

// File: rtl/scsi_seq_timer.sv
module scsi_seq_timer #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/scsi_seq_lines.sv
module scsi_seq_lines (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       apply,
  input  logic       release_i,
  input  logic [2:0] bits_in,
  output logic [2:0] cur_bits,
  output logic       cur_free
);

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      cur_bits <= 3'b000;
      cur_free <= 1'b1;
    end else if (release_i) begin
      cur_bits <= 3'b000;
      cur_free <= 1'b1;
    end else if (apply) begin
      cur_bits <= bits_in;
      cur_free <= 1'b0;
    end
  end

endmodule

// File: rtl/scsi_seq_ctrl.sv
module scsi_seq_ctrl
  import scsi_seq_pkg::*;
#(
  parameter int CNT_W = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_rst,
  input  logic               req_valid,
  input  logic [PHASE_W-1:0] req_phase,
  input  logic               legacy_in,
  input  logic               ack_in,
  input  logic               same_phase,
  input  logic               timer_zero,
  input  logic [CNT_W-1:0]   settle_m1,
  input  logic [CNT_W-1:0]   pre_m1,
  output logic               req_ready,
  output logic [2:0]         tgt_bits,
  output logic               legacy_q,
  output logic               timer_load,
  output logic [CNT_W-1:0]   timer_val,
  output logic               apply,
  output logic               release_o,
  output logic               done
);

  seq_state_t state, nxt;
  logic       tgt_rel;
  logic       accept;
  logic       tgt_is_data;
  logic       done_d;

  assign req_ready   = (state == ST_IDLE) && !bus_rst;
  assign accept      = req_valid && req_ready;
  assign tgt_is_data = !tgt_bits[2] && !tgt_bits[1];

  always_comb begin
    nxt        = state;
    apply      = 1'b0;
    release_o  = 1'b0;
    timer_load = 1'b0;
    timer_val  = '0;
    done_d     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (same_phase) done_d = 1'b1;
          else            nxt    = ST_ACKWAIT;
        end
      end
      ST_ACKWAIT: begin
        if (!ack_in) begin
          if (tgt_rel) begin
            release_o = 1'b1;
            done_d    = 1'b1;
            nxt       = ST_IDLE;
          end else if (legacy_q && tgt_is_data) begin
            timer_load = 1'b1;
            timer_val  = pre_m1;
            nxt        = ST_PRE;
          end else begin
            apply      = 1'b1;
            timer_load = 1'b1;
            timer_val  = settle_m1;
            nxt        = ST_SETTLE;
          end
        end
      end
      ST_PRE: begin
        if (timer_zero) begin
          apply      = 1'b1;
          timer_load = 1'b1;
          timer_val  = settle_m1;
          nxt        = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (timer_zero) begin
          done_d = 1'b1;
          nxt    = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || bus_rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_rel  <= 1'b1;
      tgt_bits <= 3'b000;
      legacy_q <= 1'b0;
    end else if (accept) begin
      tgt_rel  <= req_phase[REL_BIT];
      tgt_bits <= req_phase[2:0];
      legacy_q <= legacy_in;
    end
  end

endmodule

// File: rtl/scsi_phase_seq.sv
module scsi_phase_seq
  import scsi_seq_pkg::*;
#(
  parameter int CLK_PS    = 5000,
  parameter int SETTLE_NS = 400,
  parameter int IOFLIP_NS = 400,
  parameter int LEGACY_NS = 100000,
  parameter int PRE_NS    = 400000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [3:0] req_phase,
  input  logic       legacy_mode,
  input  logic       ack_in,
  input  logic       bus_rst,
  output logic       phase_msg,
  output logic       phase_cd,
  output logic       phase_io,
  output logic       drv_en,
  output logic       done
);

  localparam int MAX_SET = ns_to_cyc(SETTLE_NS, CLK_PS) + ns_to_cyc(IOFLIP_NS, CLK_PS)
                         + ns_to_cyc(LEGACY_NS, CLK_PS);
  localparam int MAX_PRE = ns_to_cyc(PRE_NS, CLK_PS);
  localparam int MAX_ALL = (MAX_SET > MAX_PRE) ? MAX_SET : MAX_PRE;
  localparam int CNT_W   = $clog2(MAX_ALL + 1);

  logic [2:0]       cur_bits;
  logic             cur_free;
  logic [2:0]       tgt_bits;
  logic             legacy_q;
  logic             same_phase;
  logic             io_flip;
  logic             timer_load;
  logic             timer_zero;
  logic [CNT_W-1:0] timer_val;
  logic [CNT_W-1:0] settle_m1;
  logic [CNT_W-1:0] pre_m1;
  logic             apply;
  logic             release_s;

  // release codes match bus-free whatever their low bits
  assign same_phase = req_phase[REL_BIT] ? cur_free
                                         : (!cur_free && (req_phase[2:0] == cur_bits));
  // a released I/O line counts as 0
  assign io_flip    = tgt_bits[0] != (cur_free ? 1'b0 : cur_bits[0]);

  scsi_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rst    (bus_rst),
    .req_valid  (req_valid),
    .req_phase  (req_phase),
    .legacy_in  (legacy_mode),
    .ack_in     (ack_in),
    .same_phase (same_phase),
    .timer_zero (timer_zero),
    .settle_m1  (settle_m1),
    .pre_m1     (pre_m1),
    .req_ready  (req_ready),
    .tgt_bits   (tgt_bits),
    .legacy_q   (legacy_q),
    .timer_load (timer_load),
    .timer_val  (timer_val),
    .apply      (apply),
    .release_o  (release_s),
    .done       (done)
  );

  scsi_seq_delay #(
    .CLK_PS    (CLK_PS),
    .SETTLE_NS (SETTLE_NS),
    .IOFLIP_NS (IOFLIP_NS),
    .LEGACY_NS (LEGACY_NS),
    .PRE_NS    (PRE_NS),
    .CNT_W     (CNT_W)
  ) u_delay (
    .legacy    (legacy_q),
    .io_flip   (io_flip),
    .settle_m1 (settle_m1),
    .pre_m1    (pre_m1)
  );

  scsi_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort    (bus_rst),
    .load     (timer_load),
    .load_val (timer_val),
    .zero     (timer_zero)
  );

  scsi_seq_lines u_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (bus_rst),
    .apply     (apply),
    .release_i (release_s),
    .bits_in   (tgt_bits),
    .cur_bits  (cur_bits),
    .cur_free  (cur_free)
  );

  assign phase_msg = cur_bits[2];
  assign phase_cd  = cur_bits[1];
  assign phase_io  = cur_bits[0];
  assign drv_en    = !cur_free;

endmodule

// File: rtl/scsi_phase_seq_chk.sv
module scsi_phase_seq_chk
  import scsi_seq_pkg::*;
#(
  parameter int CLK_PS    = 5000,
  parameter int SETTLE_NS = 400
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [3:0] req_phase,
  input logic       ack_in,
  input logic       bus_rst,
  input logic       phase_msg,
  input logic       phase_cd,
  input logic       phase_io,
  input logic       drv_en,
  input logic       done
);

  localparam int S_CYC = ns_to_cyc(SETTLE_NS, CLK_PS);

  logic [3:0]  lines;
  logic [3:0]  prev_lines;
  logic [31:0] since_chg;
  logic        same_req;

  assign lines    = {drv_en, phase_msg, phase_cd, phase_io};
  assign same_req = req_phase[3] ? !drv_en
                                 : (drv_en && (req_phase[2:0] == {phase_msg, phase_cd, phase_io}));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_lines <= 4'b0000;
      since_chg  <= 32'hFFFF_FFFF;
    end else begin
      prev_lines <= lines;
      if (lines != prev_lines)            since_chg <= 32'd0;
      else if (since_chg != 32'hFFFF_FFFF) since_chg <= since_chg + 32'd1;
    end
  end

  // R4: lines never move on an edge where ACK was asserted
  a_r4_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bus_rst) && (lines != $past(lines))) |-> !$past(ack_in));

  // R2: an accepted request leaves the block busy unless it completed at once
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
    (req_valid && req_ready) |=> (!req_ready || done));

  // R3: same-phase request completes next cycle with the lines unchanged
  a_r3_same_phase: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
    (req_valid && req_ready && same_req) |=> (done && $stable(lines)));

  // R9: reset flag forces bus-free with no completion
  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (!drv_en && !done && !req_ready || !drv_en && !done));

  // R6: released drivers carry no phase bits
  a_r6_released_low: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> !(phase_msg || phase_cd || phase_io));

  // R7: a done pulse with drivers on never comes before the base settle time
  a_r7_settle_min: assert property (@(posedge clk) disable iff (!rst_n)
    (done && drv_en) |-> ((since_chg + 32'd1) >= 32'(S_CYC)));

endmodule

bind scsi_phase_seq scsi_phase_seq_chk #(
  .CLK_PS    (CLK_PS),
  .SETTLE_NS (SETTLE_NS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_phase (req_phase),
  .ack_in    (ack_in),
  .bus_rst   (bus_rst),
  .phase_msg (phase_msg),
  .phase_cd  (phase_cd),
  .phase_io  (phase_io),
  .drv_en    (drv_en),
  .done      (done)
);

// File: tb/test_scsi_phase_seq.sv
`timescale 1ns/1ps
module test_scsi_phase_seq;

  localparam int CLK_PS    = 5000;
  localparam int SETTLE_NS = 20;
  localparam int IOFLIP_NS = 13;
  localparam int LEGACY_NS = 50;
  localparam int PRE_NS    = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [3:0] req_phase = 4'b1000;
  logic       legacy_mode = 1'b0;
  logic       ack_in = 1'b0;
  logic       bus_rst = 1'b0;
  logic       phase_msg, phase_cd, phase_io, drv_en, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  scsi_phase_seq #(
    .CLK_PS(CLK_PS), .SETTLE_NS(SETTLE_NS), .IOFLIP_NS(IOFLIP_NS),
    .LEGACY_NS(LEGACY_NS), .PRE_NS(PRE_NS)
  ) i_scsi_phase_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_phase(req_phase), .legacy_mode(legacy_mode), .ack_in(ack_in),
    .bus_rst(bus_rst), .phase_msg(phase_msg), .phase_cd(phase_cd),
    .phase_io(phase_io), .drv_en(drv_en), .done(done)
  );

  function automatic int cyc(input int ns);
    int c;
    c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] lines_now();
    return {drv_en, phase_msg, phase_cd, phase_io};
  endfunction

  // issue one request; report edge index of first line change and of done
  task automatic do_req(input logic [3:0] ph, input bit leg, input int ack_hold,
                        output int k_lines, output int k_done, output bit busy_rdy,
                        output logic [3:0] end_lines);
    logic [3:0] prev;
    int guard;
    guard = 0;
    @(negedge clk);
    while (!req_ready && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    req_phase   = ph;
    legacy_mode = leg;
    req_valid   = 1'b1;
    ack_in      = (ack_hold > 0);
    prev        = lines_now();
    k_lines     = -1;
    k_done      = -1;
    busy_rdy    = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (ack_hold == 0) ack_in = 1'b0;
    if (done) k_done = 0;
    else if (req_ready) busy_rdy = 1'b1;
    for (int k = 1; k < 300 && k_done < 0; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k_lines < 0 && lines_now() != prev) k_lines = k;
      if (done) k_done = k;
      else if (req_ready) busy_rdy = 1'b1;
      if (k == ack_hold) ack_in = 1'b0;
    end
    end_lines = lines_now();
  endtask

  function automatic logic [3:0] code_of(input int p);
    return (p == 8) ? 4'b1000 : 4'(p);
  endfunction

  initial begin
    int kl, kd;
    bit br;
    logic [3:0] el;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(lines_now() == 4'b0000, "R1 lines after reset", int'(lines_now()), 0);
    chk(done == 1'b0, "R1 done after reset", done, 0);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

    // exhaustive sweep of from/to pairs in both modes
    for (int leg = 0; leg < 2; leg++) begin
      for (int f = 0; f < 9; f++) begin
        for (int t = 0; t < 9; t++) begin
          int exp_l, exp_d, n, pre, io_f;
          logic [3:0] exp_end;
          do_req(code_of(f), 1'b0, 0, kl, kd, br, el);
          do_req(code_of(t), leg[0], 0, kl, kd, br, el);
          if (t == f) begin
            chk(kd == 0, "R3 same-phase done", kd, 0);
            chk(kl == -1, "R3 same-phase no change", kl, -1);
          end else if (t == 8) begin
            chk(kd == 1, "R6 release done", kd, 1);
            chk(kl == 1, "R6 release edge", kl, 1);
            chk(el == 4'b0000, "R6 released lines", int'(el), 0);
            chk(!br, "R2 ready low while busy", br, 0);
          end else begin
            io_f  = (f == 8) ? 0 : (f & 1);
            n     = cyc(SETTLE_NS) + (((t & 1) != io_f) ? cyc(IOFLIP_NS) : 0)
                  + (leg ? cyc(LEGACY_NS) : 0);
            pre   = (leg && t < 2) ? cyc(PRE_NS) : 0;
            exp_l = 1 + pre;
            exp_d = 1 + pre + n;
            exp_end = {1'b1, 3'(t)};
            chk(kl == exp_l, "R8 line change edge", kl, exp_l);
            chk(kd == exp_d, "R7 R10 settle done edge", kd, exp_d);
            chk(el == exp_end, "R5 driven lines", int'(el), int'(exp_end));
            chk(!br, "R2 ready low while busy", br, 0);
          end
        end
      end
    end

    // R4: ACK held high delays the change
    do_req(4'b0010, 1'b0, 0, kl, kd, br, el);
    do_req(4'b0110, 1'b0, 6, kl, kd, br, el);
    chk(kl == 7, "R4 change after ACK drops", kl, 7);
    chk(kd == 7 + cyc(SETTLE_NS), "R4 done after ACK wait", kd, 7 + cyc(SETTLE_NS));
    // R3 with ACK high
    do_req(4'b0110, 1'b0, 5, kl, kd, br, el);
    chk(kd == 0, "R3 same phase ignores ACK", kd, 0);
    ack_in = 1'b0;
    // R4 on release
    do_req(4'b1000, 1'b0, 4, kl, kd, br, el);
    chk(kl == 5 && kd == 5, "R4 release waits ACK", kd, 5);

    // R5: release with nonzero low bits is treated as release
    do_req(4'b0011, 1'b0, 0, kl, kd, br, el);
    do_req(4'b1101, 1'b0, 0, kl, kd, br, el);
    chk(el == 4'b0000, "R5 release ignores low bits", int'(el), 0);
    do_req(4'b1111, 1'b0, 0, kl, kd, br, el);
    chk(kd == 0 && kl == -1, "R5 release while free is same phase", kd, 0);

    // R9: reset flag aborts a legacy pre-data wait
    do_req(4'b0111, 1'b0, 0, kl, kd, br, el);
    @(negedge clk);
    req_phase = 4'b0001; legacy_mode = 1'b1; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    bus_rst = 1'b1;
    @(negedge clk);
    chk(drv_en == 1'b0, "R9 drivers released on reset", drv_en, 0);
    chk(req_ready == 1'b0, "R9 ready low during reset", req_ready, 1'b0);
    @(negedge clk);
    bus_rst = 1'b0;
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        if (done || drv_en) seen++;
      end
      chk(seen == 0, "R9 aborted request never completes", seen, 0);
    end
    chk(req_ready == 1'b1, "R9 ready after reset clears", req_ready, 1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule